// File: doc/BRIEF.md
# I/O-Mapped Watchdog Reset Timer

This block guards a processor system against runaway software. It occupies a single 8-bit control register at I/O address 0x455 on a simple synchronous bus with an address, single-cycle read and write strobes, and byte-wide data lines. Software arms or disarms the timer through the top bit of that register. Once armed, any read of the register keeps the timer alive. If an armed timer goes a full timeout without a read, the block drives a system reset pulse of fixed length.

A static configuration input decides whether the register exists at all. With that input low, bus cycles to the address are ignored, the read data lines are not driven, and no reset can be produced. Raising the input leaves the timer disarmed until software arms it. The timeout is counted in ticks of a prescaled clock. Both the prescale ratio and the tick count are parameters, so simulation can use very short timeouts.

Top module: `wdt_io_watchdog`

## Requirements
- R1: The register responds only to cycles whose 16-bit address equals 0x455 exactly. A read or write at any other address has no effect and leaves `bus_rdata_oe` low.
- R2: A write to 0x455 sets the armed state to bit 7 of the write data (1 = armed, 0 = disarmed). Bits 6..0 of the write data are ignored.
- R3: During a read of 0x455, `bus_rdata_oe` is high and `bus_rdata` equals {armed, 7'b0}. When no read hits, `bus_rdata` is 0 and `bus_rdata_oe` is low.
- R4: Arming from the disarmed state loads the full timeout. With no refresh, `wdt_rst_out` rises exactly TICK_DIV*TIMEOUT_TICKS clock edges after the edge that captured the arming write.
- R5: A read of 0x455 while armed reloads the timeout. `wdt_rst_out` then rises TICK_DIV*TIMEOUT_TICKS edges after the edge that captured the read.
- R6: A write of bit 7 = 1 while already armed does not reload the timeout. Expiry keeps the schedule set by the last arming or refresh.
- R7: Disarming stops the countdown, so no reset is produced. A later arming again waits the full timeout.
- R8: `wdt_rst_out` stays high for exactly RST_LEN cycles. The expiry clears the armed state. Writes captured while the pulse is high are ignored.
- R9: While `cfg_en` is low, all bus cycles are ignored, `bus_rdata_oe` stays low, no reset pulse starts, and the armed state is cleared. Raising `cfg_en` does not arm the timer.
- R10: The synchronous reset input `rst` clears the armed state and the countdown without producing a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high system reset |
| cfg_en | input | 1 | Static configuration: register present when high |
| bus_addr | input | 16 | I/O address |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not driven |
| bus_rdata_oe | output | 1 | High when the block drives `bus_rdata` |
| wdt_rst_out | output | 1 | System reset pulse on expiry |

## Verification
Read data and its enable are combinational from the strobe, so the bench samples them in the same cycle the read is presented. Armed-state changes show on the next read. The reset output rises exactly TICK_DIV*TIMEOUT_TICKS edges after the edge that captured the arming write or the last refresh read. It stays high for RST_LEN cycles. The bench counts edges from that capture edge and checks the output low at every sample before the expected edge, high from it on, and low again after the pulse. All samples are taken on the falling edge. The refresh and redundant-arm cases are swept over every offset inside one timeout window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int              BUS_AW      = 16;
    localparam int              BUS_DW      = 8;
    localparam logic [BUS_AW-1:0] WDT_REG_ADDR = 16'h0455;
    localparam int              ARM_BIT     = 7;

    // Decoded bus cycle that reached the register
    typedef struct packed {
        logic rd_hit;
        logic wr_hit;
        logic wr_arm;
    } wdt_cmd_t;

    // Control state: disarmed, counting, or driving the reset pulse
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wdt_state_t;

    function automatic logic addr_match(input logic [BUS_AW-1:0] a);
        return a == WDT_REG_ADDR;
    endfunction

    function automatic logic [BUS_DW-1:0] pack_status(input logic armed);
        logic [BUS_DW-1:0] v;
        v          = '0;
        v[ARM_BIT] = armed;
        return v;
    endfunction

endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
    import wdt_pkg::*;
(
    input  logic              cfg_en,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              armed,
    output wdt_cmd_t          cmd,
    output logic [BUS_DW-1:0] rdata,
    output logic              rdata_oe
);

    logic sel;
    logic unused_rsvd;

    // Reserved write bits carry no function
    assign unused_rsvd = ^bus_wdata[ARM_BIT-1:0];

    assign sel = cfg_en && addr_match(bus_addr);

    always_comb begin
        cmd.rd_hit = sel && bus_rd;
        cmd.wr_hit = sel && bus_wr;
        cmd.wr_arm = bus_wdata[ARM_BIT];
    end

    assign rdata_oe = cmd.rd_hit;
    assign rdata    = cmd.rd_hit ? pack_status(armed) : '0;

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int TICK_DIV      = 1000,
    parameter int TIMEOUT_TICKS = 1100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic refresh,
    output logic expire
);

    localparam int LW = $clog2(TIMEOUT_TICKS + 1);

    logic          tick;
    logic [LW-1:0] left_q;
    logic          hold;

    assign hold = rst || !run || refresh;

    generate
        if (TICK_DIV > 1) begin : g_prescale
            localparam int PW = $clog2(TICK_DIV);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (hold || tick) pre_q <= '0;
                else              pre_q <= pre_q + PW'(1);
            end

            assign tick = (pre_q == PW'(TICK_DIV - 1));
        end else begin : g_direct
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (hold) begin
            left_q <= LW'(TIMEOUT_TICKS);
        end else if (tick && left_q != LW'(1)) begin
            left_q <= left_q - LW'(1);
        end
    end

    assign expire = run && !refresh && tick && (left_q == LW'(1));

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
    parameter int RST_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse,
    output logic last
);

    localparam int CW = $clog2(RST_LEN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (fire)            cnt_q <= CW'(RST_LEN);
        else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
    end

    assign pulse = (cnt_q != '0);
    assign last  = (cnt_q == CW'(1));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_en,
    input  wdt_cmd_t cmd,
    input  logic     expire,
    input  logic     pulse_last,
    output logic     armed,
    output logic     fire_now
);

    wdt_state_t state_q;
    wdt_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd.wr_hit && cmd.wr_arm) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!cfg_en)                        state_d = ST_IDLE;
                else if (cmd.wr_hit && !cmd.wr_arm) state_d = ST_IDLE;
                else if (expire)                    state_d = ST_FIRE;
            end
            ST_FIRE: begin
                if (pulse_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign armed    = (state_q == ST_RUN);
    assign fire_now = (state_q == ST_RUN) && (state_d == ST_FIRE);

endmodule

// File: rtl/wdt_io_watchdog.sv
module wdt_io_watchdog
    import wdt_pkg::*;
#(
    parameter int TICK_DIV      = 1000,
    parameter int TIMEOUT_TICKS = 1100,
    parameter int RST_LEN       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              bus_rdata_oe,
    output logic              wdt_rst_out
);

    wdt_cmd_t cmd;
    logic     armed;
    logic     expire;
    logic     fire_now;
    logic     pulse_last;

    wdt_bus_decode u_dec (
        .cfg_en   (cfg_en),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .armed    (armed),
        .cmd      (cmd),
        .rdata    (bus_rdata),
        .rdata_oe (bus_rdata_oe)
    );

    wdt_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_en    (cfg_en),
        .cmd       (cmd),
        .expire    (expire),
        .pulse_last(pulse_last),
        .armed     (armed),
        .fire_now  (fire_now)
    );

    wdt_countdown #(
        .TICK_DIV     (TICK_DIV),
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (armed && cfg_en),
        .refresh(cmd.rd_hit),
        .expire (expire)
    );

    wdt_pulse_gen #(
        .RST_LEN(RST_LEN)
    ) u_pulse (
        .clk  (clk),
        .rst  (rst),
        .fire (fire_now),
        .pulse(wdt_rst_out),
        .last (pulse_last)
    );

endmodule

// File: rtl/wdt_io_watchdog_chk.sv
module wdt_io_watchdog_chk #(
    parameter int RST_LEN = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_en,
    input logic [15:0] bus_addr,
    input logic        bus_wr,
    input logic        wr_arm,
    input logic [7:0]  bus_rdata,
    input logic        bus_rdata_oe,
    input logic        wdt_rst_out,
    input logic        armed
);

    int hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)              hi_cnt <= 0;
        else if (wdt_rst_out) hi_cnt <= hi_cnt + 1;
        else                  hi_cnt <= 0;
    end

    a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[6:0] == 7'd0);

    a_r3_readback: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_oe |-> (bus_rdata[7] == armed));

    a_r9_no_oe_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |-> !bus_rdata_oe);

    a_r9_no_fire_off: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !wdt_rst_out) |=> !wdt_rst_out);

    a_r4_fire_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_rst_out) |-> $past(armed));

    a_r8_pulse_max: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_out |-> (hi_cnt < RST_LEN));

    a_r8_pulse_full: assert property (@(posedge clk) disable iff (rst)
        $fell(wdt_rst_out) |-> (hi_cnt == RST_LEN));

    a_r8_disarmed_in_pulse: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_out |-> !armed);

    a_r2_arm_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && cfg_en && bus_addr == 16'h0455 && wr_arm && !armed && !wdt_rst_out)
        |=> armed);

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!armed && !wdt_rst_out));

endmodule

bind wdt_io_watchdog wdt_io_watchdog_chk #(
    .RST_LEN(RST_LEN)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_en      (cfg_en),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .wr_arm      (bus_wdata[7]),
    .bus_rdata   (bus_rdata),
    .bus_rdata_oe(bus_rdata_oe),
    .wdt_rst_out (wdt_rst_out),
    .armed       (armed)
);

// File: tb/tb_wdt_io_watchdog.sv
module tb_wdt_io_watchdog;

    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 3;
    localparam int TICKS = 5;
    localparam int PLEN  = 4;
    localparam int N     = DIV * TICKS;
    localparam logic [15:0] RA = 16'h0455;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b1;
    logic [15:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic       rst_out;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_io_watchdog #(
        .TICK_DIV     (DIV),
        .TIMEOUT_TICKS(TICKS),
        .RST_LEN      (PLEN)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_en      (cfg_en),
        .bus_addr    (addr),
        .bus_rd      (rd),
        .bus_wr      (wr),
        .bus_wdata   (wdata),
        .bus_rdata   (rdata),
        .bus_rdata_oe(rdata_oe),
        .wdt_rst_out (rst_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a, output logic [7:0] d, output logic oe);
        addr = a; rd = 1'b1;
        #1;
        d  = rdata;
        oe = rdata_oe;
        @(negedge clk);
        rd = 1'b0;
    endtask

    // Expect the pulse to rise at the n-th edge from now, then last PLEN cycles
    task automatic expect_fire(input int n, input string req);
        int early = 0;
        int hi = 0;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            if (rst_out) early++;
        end
        check(early == 0, req, early, 0);
        @(negedge clk);
        check(rst_out == 1'b1, req, rst_out, 1);
        for (int i = 1; i < PLEN; i++) begin
            @(negedge clk);
            if (rst_out) hi++;
        end
        check(hi == PLEN - 1, req, hi + 1, PLEN);
        @(negedge clk);
        check(rst_out == 1'b0, req, rst_out, 0);
    endtask

    task automatic expect_quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_out) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [7:0] d;
        logic       oe;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rst_out == 1'b0, "R10 reset state", rst_out, 0);
        do_rd(RA, d, oe);
        check(oe == 1'b1 && d == 8'h00, "R10/R3 read after reset", {oe, d}, 9'h100);

        // R2/R3: every write byte, readback holds only bit 7
        for (int v = 0; v < 256; v++) begin
            do_wr(RA, 8'(v));
            do_rd(RA, d, oe);
            check(oe == 1'b1 && d == (8'(v) & 8'h80), "R2 write/readback", d, v & 8'h80);
        end
        do_wr(RA, 8'h00);
        check(rdata_oe == 1'b0 && rdata == 8'h00, "R3 idle bus", {rdata_oe, rdata}, 0);

        // R1: single-bit address neighbours do not decode
        for (int i = 0; i < 16; i++) begin
            do_wr(RA ^ (16'h1 << i), 8'h80);
            do_rd(RA ^ (16'h1 << i), d, oe);
            check(oe == 1'b0 && d == 8'h00, "R1 foreign address", {oe, d}, 0);
        end
        do_rd(RA, d, oe);
        check(d == 8'h00, "R1 not armed by foreign write", d, 0);
        expect_quiet(2 * N, "R1 no pulse");

        // R4 + R8: plain expiry, then disarmed
        do_wr(RA, 8'h80);
        expect_fire(N, "R4 expiry timing");
        do_rd(RA, d, oe);
        check(d == 8'h00, "R8 expiry disarms", d, 0);
        expect_quiet(2 * N, "R8 stays quiet");

        // R8: write during pulse ignored
        do_wr(RA, 8'h80);
        repeat (N) @(negedge clk);
        check(rst_out == 1'b1, "R8 pulse started", rst_out, 1);
        do_wr(RA, 8'h80);
        repeat (PLEN) @(negedge clk);
        check(rst_out == 1'b0, "R8 pulse ended", rst_out, 0);
        do_rd(RA, d, oe);
        check(d == 8'h00, "R8 write in pulse ignored", d, 0);
        expect_quiet(2 * N, "R8 no second pulse");

        // R5: refresh at every offset
        for (int k = 1; k < N; k++) begin
            do_wr(RA, 8'h80);
            repeat (k - 1) @(negedge clk);
            do_rd(RA, d, oe);
            check(d == 8'h80, "R5 armed readback", d, 8'h80);
            expect_fire(N, "R5 refresh reload");
        end

        // R6: redundant arm write does not refresh
        for (int k = 1; k < N; k++) begin
            do_wr(RA, 8'h80);
            repeat (k - 1) @(negedge clk);
            do_wr(RA, 8'hFF);
            expect_fire(N - k, "R6 no refresh by write");
        end

        // R7: disarm stops, re-arm full timeout
        do_wr(RA, 8'h80);
        repeat (5) @(negedge clk);
        do_wr(RA, 8'h7F);
        do_rd(RA, d, oe);
        check(d == 8'h00, "R7 disarm readback", d, 0);
        expect_quiet(3 * N, "R7 disarmed quiet");
        do_wr(RA, 8'h80);
        expect_fire(N, "R7 re-arm full timeout");

        // R9: configuration input low
        cfg_en = 1'b0;
        do_rd(RA, d, oe);
        check(oe == 1'b0 && d == 8'h00, "R9 no drive when off", {oe, d}, 0);
        do_wr(RA, 8'h80);
        expect_quiet(3 * N, "R9 no pulse when off");
        cfg_en = 1'b1;
        do_rd(RA, d, oe);
        check(oe == 1'b1 && d == 8'h00, "R9 enable does not arm", {oe, d}, 9'h100);
        expect_quiet(3 * N, "R9 quiet after enable");
        do_wr(RA, 8'h80);
        repeat (3) @(negedge clk);
        cfg_en = 1'b0;
        expect_quiet(3 * N, "R9 drop while armed");
        cfg_en = 1'b1;
        do_rd(RA, d, oe);
        check(d == 8'h00, "R9 drop clears arm", d, 0);
        expect_quiet(2 * N, "R9 quiet after drop");

        // R10: system reset while armed
        do_wr(RA, 8'h80);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(rst_out == 1'b0, "R10 reset no pulse", rst_out, 0);
        do_rd(RA, d, oe);
        check(d == 8'h00, "R10 reset disarms", d, 0);
        expect_quiet(2 * N, "R10 quiet after reset");

        summary();
    end

endmodule